// File: doc/BRIEF.md
# Pulse-Distance Infrared Message Decoder

This block turns a demodulated infrared line into complete messages. The line is brought into the clock domain and normalised to "mark" (carrier present) and "space". The block then measures each mark-plus-space symbol in core clock cycles. A start symbol of one set length opens a message. After it, each symbol is sorted into a logic zero or a logic one by comparing its total period and its mark width against programmable windows. A silence longer than a programmed gap closes the message.

The start-symbol windows count in coarse steps of 16 cycles. For the data symbols, the period windows count in steps of 2 cycles and the width windows count in single cycles. Software programs every window, the length limits and the gap with the decoder switched off, and then switches it on. The decoder presents an accepted message as a right-aligned data word with its bit count, and holds it until software acknowledges it. Output options set the mark polarity, the bit order and whether stored bits are complemented.

Top module: `irdec_top`

## Requirements
- R1: After reset, valid_o and irq_o are 0, and data_o and len_o are all zeros.
- R2: A start symbol is accepted only when floor(period/16) lies in [ld_pd_min_i, ld_pd_max_i] and floor(mark/16) lies in [ld_w_min_i, ld_w_max_i]. Otherwise no message begins.
- R3: A data symbol is a zero when floor(period/2) lies in the b0 period window and its mark width lies in the b0 width window. It is a one when it matches the b1 windows in the same way. When both match, zero wins.
- R4: A data symbol that matches neither window abandons the message, and no valid_o results from it.
- R5: A message ends once the line has stayed in space for gap_i*8 cycles. It is accepted only when its bit count n satisfies min_len_i <= n <= max_len_i; len_o then shows n.
- R6: With pol_high_i=1 a high ir_i is a mark; with pol_high_i=0 a low ir_i is a mark.
- R7: With msb_first_i=1 the first received bit lands in data_o[n-1]. With msb_first_i=0 it lands in data_o[0]. Bits at n and above are 0.
- R8: With keep_i=1 a zero symbol stores 0 and a one symbol stores 1; with keep_i=0 each stored bit is complemented.
- R9: While valid_o is 1, data_o and len_o do not change and the line is ignored. A one-cycle ack_i clears valid_o and re-arms the decoder.
- R10: irq_o pulses for exactly one cycle, in the same cycle that valid_o first becomes 1.
- R11: With en_i=0, valid_o is cleared on the next cycle and no message is decoded.
- R12: A message that carries more than MAX_BITS (48) data symbols is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_i | input | 1 | Demodulated infrared line |
| en_i | input | 1 | Decoder enable |
| pol_high_i | input | 1 | 1: a high level is a mark |
| msb_first_i | input | 1 | 1: the first bit becomes the MSB |
| keep_i | input | 1 | 1: store bits as decoded; 0: complement them |
| ld_pd_max_i | input | 8 | Start period maximum, in units of 16 cycles |
| ld_pd_min_i | input | 8 | Start period minimum, in units of 16 cycles |
| ld_w_max_i | input | 8 | Start mark maximum, in units of 16 cycles |
| ld_w_min_i | input | 8 | Start mark minimum, in units of 16 cycles |
| b0_pd_max_i | input | 8 | Zero period maximum, in units of 2 cycles |
| b0_pd_min_i | input | 8 | Zero period minimum, in units of 2 cycles |
| b0_w_max_i | input | 8 | Zero mark maximum, in cycles |
| b0_w_min_i | input | 8 | Zero mark minimum, in cycles |
| b1_pd_max_i | input | 8 | One period maximum, in units of 2 cycles |
| b1_pd_min_i | input | 8 | One period minimum, in units of 2 cycles |
| b1_w_max_i | input | 8 | One mark maximum, in cycles |
| b1_w_min_i | input | 8 | One mark minimum, in cycles |
| min_len_i | input | 5 | Smallest accepted bit count |
| max_len_i | input | 6 | Largest accepted bit count |
| gap_i | input | 10 | Ending silence, in units of 8 cycles |
| ack_i | input | 1 | Acknowledge the held message |
| data_o | output | 48 | Received bits, right-aligned |
| len_o | output | 6 | Received bit count |
| valid_o | output | 1 | A message is held |
| irq_o | output | 1 | One-cycle strobe when a message is accepted |

## Verification
The bench aims at the window edges, where a decoder that rounds the coarse start units the wrong way, or that sums the period wrongly, would drop good messages or accept a mark that is too short or too long. It tries bit counts one below and one above the length limits, where a comparison that is off by one or the wrong way round lets a message through or loses it. It also tries a 49-symbol message, where a missing overflow check would corrupt the word. Sweeping every combination of polarity, order and inversion catches a swapped fill direction or a wrong complement. The hold, disable and overlapping-window tests catch a decoder that overwrites an unacknowledged word, stays valid while switched off, or resolves a symbol that matches both windows as a one.

// File: rtl/irdec_pkg.sv
package irdec_pkg;
  // scaling of the measured counts before window comparison
  localparam int LD_SH  = 4;  // start symbol: period and mark in 16-cycle units
  localparam int DPD_SH = 1;  // data symbol period in 2-cycle units
  localparam int DW_SH  = 0;  // data symbol mark in single cycles
  localparam int GAP_SH = 3;  // ending silence in 8-cycle units

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for a first mark edge
    ST_LEAD = 2'd1,  // measuring a start-symbol candidate
    ST_DATA = 2'd2,  // collecting data symbols
    ST_HOLD = 2'd3   // message held until acknowledged
  } irdec_state_e;
endpackage

// File: rtl/irdec_front.sv
module irdec_front #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_i,
  input  logic             pol_high_i,
  input  logic [CNT_W-1:0] gap_thr_i,
  output logic             rise_o,
  output logic             gap_o,
  output logic [CNT_W-1:0] mark_len_o,
  output logic [CNT_W:0]   period_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic             s1_q, s2_q, mark_d_q;
  logic             mark;
  logic [CNT_W-1:0] mcnt_q, mcnt_n, scnt_q, scnt_n;

  assign mark   = pol_high_i ? s2_q : ~s2_q;
  assign rise_o = mark & ~mark_d_q;

  always_comb begin
    mcnt_n = mcnt_q;
    scnt_n = scnt_q;
    if (rise_o) begin
      mcnt_n = {{(CNT_W-1){1'b0}}, 1'b1};
      scnt_n = '0;
    end else if (mark) begin
      if (mcnt_q != CNT_SAT) mcnt_n = mcnt_q + 1'b1;
    end else begin
      if (scnt_q != CNT_SAT) scnt_n = scnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      mark_d_q <= 1'b0;
      mcnt_q   <= '0;
      scnt_q   <= '0;
    end else begin
      s1_q     <= ir_i;
      s2_q     <= s1_q;
      mark_d_q <= mark;
      mcnt_q   <= mcnt_n;
      scnt_q   <= scnt_n;
    end
  end

  assign gap_o      = ~mark & (scnt_q == gap_thr_i);
  assign mark_len_o = mcnt_q;
  assign period_o   = {1'b0, mcnt_q} + {1'b0, scnt_q};

  // every accepted edge restarts the measurement of a new symbol (R2, R3)
  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> (mark_len_o == 1) && (period_o == 1));
endmodule

// File: rtl/irdec_win.sv
module irdec_win #(
  parameter int CNT_W = 16,
  parameter int PD_W  = 8,
  parameter int WD_W  = 8,
  parameter int PD_SH = 1,
  parameter int W_SH  = 0
) (
  input  logic [CNT_W-1:0] mark_len_i,
  input  logic [CNT_W:0]   period_i,
  input  logic [PD_W-1:0]  pd_max_i,
  input  logic [PD_W-1:0]  pd_min_i,
  input  logic [WD_W-1:0]  w_max_i,
  input  logic [WD_W-1:0]  w_min_i,
  output logic             hit_o
);
  logic [CNT_W:0]   pd_units;
  logic [CNT_W-1:0] w_units;
  logic [CNT_W:0]   pd_lo, pd_hi;
  logic [CNT_W-1:0] w_lo, w_hi;

  assign pd_units = period_i >> PD_SH;
  assign w_units  = mark_len_i >> W_SH;
  assign pd_lo    = {{(CNT_W+1-PD_W){1'b0}}, pd_min_i};
  assign pd_hi    = {{(CNT_W+1-PD_W){1'b0}}, pd_max_i};
  assign w_lo     = {{(CNT_W-WD_W){1'b0}}, w_min_i};
  assign w_hi     = {{(CNT_W-WD_W){1'b0}}, w_max_i};

  assign hit_o = (pd_units >= pd_lo) && (pd_units <= pd_hi) &&
                 (w_units >= w_lo) && (w_units <= w_hi);
endmodule

// File: rtl/irdec_ctrl.sv
module irdec_ctrl
  import irdec_pkg::*;
#(
  parameter int MAX_BITS = 48,
  parameter int LEN_W    = 6,
  parameter int MINL_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                msb_first_i,
  input  logic                keep_i,
  input  logic [MINL_W-1:0]   min_len_i,
  input  logic [LEN_W-1:0]    max_len_i,
  input  logic                rise_i,
  input  logic                gap_i,
  input  logic                hit_ld_i,
  input  logic                hit_b0_i,
  input  logic                hit_b1_i,
  input  logic                ack_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                valid_o,
  output logic                irq_o
);
  localparam logic [LEN_W-1:0] CNT_FULL = LEN_W'(MAX_BITS);

  irdec_state_e        st_q, st_n;
  logic [LEN_W-1:0]    cnt_q, cnt_n;
  logic [MAX_BITS-1:0] sh_q, sh_n, dat_q, dat_n;
  logic [LEN_W-1:0]    len_q, len_n;
  logic                val_q, val_n, irq_q, irq_n;
  logic                sym_ok, bit_val, len_ok;
  logic [LEN_W-1:0]    min_ext;

  assign sym_ok  = hit_b0_i | hit_b1_i;
  // a symbol that matches the zero window is a zero, even if it also matches one
  assign bit_val = keep_i ? ~hit_b0_i : hit_b0_i;
  assign min_ext = {{(LEN_W-MINL_W){1'b0}}, min_len_i};
  assign len_ok  = (cnt_q >= min_ext) && (cnt_q <= max_len_i);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    dat_n = dat_q;
    len_n = len_q;
    val_n = val_q;
    irq_n = 1'b0;
    if (!en_i) begin
      st_n  = ST_IDLE;
      val_n = 1'b0;
      cnt_n = '0;
      sh_n  = '0;
    end else begin
      case (st_q)
        ST_IDLE: if (rise_i) st_n = ST_LEAD;
        ST_LEAD: begin
          if (rise_i) begin
            if (hit_ld_i) begin
              st_n  = ST_DATA;
              cnt_n = '0;
              sh_n  = '0;
            end
          end else if (gap_i) begin
            st_n = ST_IDLE;
          end
        end
        ST_DATA: begin
          if (rise_i) begin
            if (sym_ok && (cnt_q < CNT_FULL)) begin
              cnt_n = cnt_q + 1'b1;
              if (msb_first_i) sh_n = {sh_q[MAX_BITS-2:0], bit_val};
              else             sh_n[cnt_q] = bit_val;
            end else begin
              st_n = ST_LEAD;  // abandon; this edge may open a new start symbol
            end
          end else if (gap_i) begin
            if (len_ok) begin
              st_n  = ST_HOLD;
              val_n = 1'b1;
              irq_n = 1'b1;
              dat_n = sh_q;
              len_n = cnt_q;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_HOLD: begin
          if (ack_i) begin
            st_n  = ST_IDLE;
            val_n = 1'b0;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      dat_q <= '0;
      len_q <= '0;
      val_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      val_q <= val_n;
      irq_q <= irq_n;
      if (irq_n) begin
        dat_q <= dat_n;
        len_q <= len_n;
      end
    end
  end

  assign data_o  = dat_q;
  assign len_o   = len_q;
  assign valid_o = val_q;
  assign irq_o   = irq_q;

  assert_cnt_max_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(val_q) |-> (len_q >= min_ext) && (len_q <= max_len_i));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q && !ack_i && en_i) |=> val_q && $stable(dat_q) && $stable(len_q));
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  assert_irq_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> val_q && !$past(val_q));
  assert_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !val_q);
endmodule

// File: rtl/irdec_top.sv
module irdec_top
  import irdec_pkg::*;
#(
  parameter int MAX_BITS = 48,
  parameter int CNT_W    = 16,
  parameter int PD_W     = 8,
  parameter int WD_W     = 8,
  parameter int FT_W     = 10,
  parameter int MINL_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ir_i,
  input  logic                          en_i,
  input  logic                          pol_high_i,
  input  logic                          msb_first_i,
  input  logic                          keep_i,
  input  logic [PD_W-1:0]               ld_pd_max_i,
  input  logic [PD_W-1:0]               ld_pd_min_i,
  input  logic [WD_W-1:0]               ld_w_max_i,
  input  logic [WD_W-1:0]               ld_w_min_i,
  input  logic [PD_W-1:0]               b0_pd_max_i,
  input  logic [PD_W-1:0]               b0_pd_min_i,
  input  logic [WD_W-1:0]               b0_w_max_i,
  input  logic [WD_W-1:0]               b0_w_min_i,
  input  logic [PD_W-1:0]               b1_pd_max_i,
  input  logic [PD_W-1:0]               b1_pd_min_i,
  input  logic [WD_W-1:0]               b1_w_max_i,
  input  logic [WD_W-1:0]               b1_w_min_i,
  input  logic [MINL_W-1:0]             min_len_i,
  input  logic [$clog2(MAX_BITS+1)-1:0] max_len_i,
  input  logic [FT_W-1:0]               gap_i,
  input  logic                          ack_i,
  output logic [MAX_BITS-1:0]           data_o,
  output logic [$clog2(MAX_BITS+1)-1:0] len_o,
  output logic                          valid_o,
  output logic                          irq_o
);
  localparam int LEN_W = $clog2(MAX_BITS+1);
  localparam int GAP_W = FT_W + GAP_SH;
  localparam int NWIN  = 3;  // 0: start symbol, 1: zero, 2: one

  logic             rs1_q, rs2_q;
  logic             rst_int_n;
  logic             rise, gap;
  logic [CNT_W-1:0] mark_len, gap_thr;
  logic [CNT_W:0]   period;
  logic [NWIN-1:0]  hit;
  logic [PD_W-1:0]  pd_max_a [NWIN];
  logic [PD_W-1:0]  pd_min_a [NWIN];
  logic [WD_W-1:0]  w_max_a  [NWIN];
  logic [WD_W-1:0]  w_min_a  [NWIN];

  // reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  assign gap_thr = {{(CNT_W-GAP_W){1'b0}}, gap_i, {GAP_SH{1'b0}}};

  irdec_front #(.CNT_W(CNT_W)) u_front (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ir_i       (ir_i),
    .pol_high_i (pol_high_i),
    .gap_thr_i  (gap_thr),
    .rise_o     (rise),
    .gap_o      (gap),
    .mark_len_o (mark_len),
    .period_o   (period)
  );

  assign pd_max_a[0] = ld_pd_max_i;  assign pd_min_a[0] = ld_pd_min_i;
  assign w_max_a[0]  = ld_w_max_i;   assign w_min_a[0]  = ld_w_min_i;
  assign pd_max_a[1] = b0_pd_max_i;  assign pd_min_a[1] = b0_pd_min_i;
  assign w_max_a[1]  = b0_w_max_i;   assign w_min_a[1]  = b0_w_min_i;
  assign pd_max_a[2] = b1_pd_max_i;  assign pd_min_a[2] = b1_pd_min_i;
  assign w_max_a[2]  = b1_w_max_i;   assign w_min_a[2]  = b1_w_min_i;

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    localparam int PSH = (gi == 0) ? LD_SH : DPD_SH;
    localparam int WSH = (gi == 0) ? LD_SH : DW_SH;
    irdec_win #(
      .CNT_W (CNT_W), .PD_W (PD_W), .WD_W (WD_W), .PD_SH (PSH), .W_SH (WSH)
    ) u_win (
      .mark_len_i (mark_len),
      .period_i   (period),
      .pd_max_i   (pd_max_a[gi]),
      .pd_min_i   (pd_min_a[gi]),
      .w_max_i    (w_max_a[gi]),
      .w_min_i    (w_min_a[gi]),
      .hit_o      (hit[gi])
    );
  end

  irdec_ctrl #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .MINL_W(MINL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (en_i),
    .msb_first_i (msb_first_i),
    .keep_i      (keep_i),
    .min_len_i   (min_len_i),
    .max_len_i   (max_len_i),
    .rise_i      (rise),
    .gap_i       (gap),
    .hit_ld_i    (hit[0]),
    .hit_b0_i    (hit[1]),
    .hit_b1_i    (hit[2]),
    .ack_i       (ack_i),
    .data_o      (data_o),
    .len_o       (len_o),
    .valid_o     (valid_o),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/irdec_top_tb.sv
`timescale 1ns/1ps
module irdec_top_tb;
  logic        clk = 1'b0;
  logic        rst_n, ir, en, pol, msb, keep, ack;
  logic [7:0]  ld_pmax, ld_pmin, ld_wmax, ld_wmin;
  logic [7:0]  z_pmax, z_pmin, z_wmax, z_wmin, o_pmax, o_pmin, o_wmax, o_wmin;
  logic [4:0]  min_len;
  logic [5:0]  max_len;
  logic [9:0]  gap;
  logic [47:0] data;
  logic [5:0]  len;
  logic        valid, irq;

  int checks = 0;
  int fails  = 0;
  bit got_v, irq0, irq1;
  int lens [5] = '{2, 9, 24, 37, 48};

  always #10 clk = ~clk;

  irdec_top u_dut (
    .clk(clk), .rst_n(rst_n), .ir_i(ir), .en_i(en), .pol_high_i(pol),
    .msb_first_i(msb), .keep_i(keep),
    .ld_pd_max_i(ld_pmax), .ld_pd_min_i(ld_pmin), .ld_w_max_i(ld_wmax), .ld_w_min_i(ld_wmin),
    .b0_pd_max_i(z_pmax), .b0_pd_min_i(z_pmin), .b0_w_max_i(z_wmax), .b0_w_min_i(z_wmin),
    .b1_pd_max_i(o_pmax), .b1_pd_min_i(o_pmin), .b1_w_max_i(o_wmax), .b1_w_min_i(o_wmin),
    .min_len_i(min_len), .max_len_i(max_len), .gap_i(gap), .ack_i(ack),
    .data_o(data), .len_o(len), .valid_o(valid), .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic level(input logic lv, input int n);
    ir = lv;
    repeat (n) @(negedge clk);
  endtask

  // start symbol: ldm mark + 32 space; zero 8+8; one 8+24; bad symbol 8+40
  task automatic send(input int n, input logic [63:0] b, input int ldm, input int bad);
    level(pol, ldm);
    level(~pol, 32);
    for (int i = 0; i < n; i++) begin
      level(pol, 8);
      level(~pol, (i == bad) ? 40 : (b[i] ? 24 : 8));
    end
    level(pol, 8);
    ir = ~pol;
  endtask

  task automatic wait_end();
    got_v = 0; irq0 = 0; irq1 = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (valid && !got_v) begin
        got_v = 1;
        irq0  = irq;
        @(negedge clk);
        irq1  = irq;
      end
    end
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  function automatic logic [63:0] exp_data(input int n, input logic [63:0] b, input bit m, input bit k);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < n; i++) begin
      if (m) r[n-1-i] = k ? b[i] : ~b[i];
      else   r[i]     = k ? b[i] : ~b[i];
    end
    return r;
  endfunction

  task automatic good_msg(input int n, input logic [63:0] b, input string tag);
    send(n, b, 64, -1);
    wait_end();
    check(got_v, {tag, " valid"}, 64'(got_v), 64'd1);
    check({16'h0, data} == exp_data(n, b, msb, keep), {tag, " data"}, {16'h0, data}, exp_data(n, b, msb, keep));
    check(len == 6'(n), {tag, " len"}, 64'(len), 64'(n));
    check(irq0 && !irq1, "R10 irq single pulse with valid", {irq0, irq1}, 64'd2);
    do_ack();
    check(!valid, "R9 ack clears valid", 64'(valid), 64'd0);
  endtask

  task automatic no_msg(input int n, input logic [63:0] b, input int ldm, input int bad, input string tag);
    send(n, b, ldm, bad);
    wait_end();
    check(!got_v, tag, 64'(got_v), 64'd0);
    if (got_v) do_ack();
  endtask

  task automatic reconfig(input bit p, input bit m, input bit k);
    en = 1'b0; pol = p; msb = m; keep = k; ir = ~p;
    repeat (100) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    rst_n = 1'b0; ir = 1'b0; en = 1'b0; pol = 1'b1; msb = 1'b0; keep = 1'b1; ack = 1'b0;
    ld_pmin = 8'd5; ld_pmax = 8'd7; ld_wmin = 8'd3; ld_wmax = 8'd5;
    z_pmin = 8'd7;  z_pmax = 8'd9;  z_wmin = 8'd6;  z_wmax = 8'd10;
    o_pmin = 8'd15; o_pmax = 8'd17; o_wmin = 8'd6;  o_wmax = 8'd10;
    min_len = 5'd2; max_len = 6'd48; gap = 10'd8;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(!valid, "R1 valid after reset", 64'(valid), 64'd0);
    check(!irq, "R1 irq after reset", 64'(irq), 64'd0);
    check(data == '0, "R1 data after reset", 64'(data), 64'd0);
    check(len == '0, "R1 len after reset", 64'(len), 64'd0);

    // R3 R6 R7 R8: every polarity, order and inversion over several lengths
    for (int c = 0; c < 8; c++) begin
      reconfig(c[0], c[1], c[2]);
      for (int k = 0; k < 5; k++) begin
        pat = 64'h9E3779B97F4A7C15 * 64'(c * 5 + k + 1);
        pat = pat ^ (pat >> 29);
        good_msg(lens[k], pat, $sformatf("R3 R6 R7 R8 cfg%0d len%0d", c, lens[k]));
      end
    end

    reconfig(1'b1, 1'b0, 1'b1);
    // R2 start symbol too short and too long
    no_msg(10, 64'h2AB, 32, -1, "R2 short start symbol rejected");
    no_msg(10, 64'h2AB, 96, -1, "R2 long start symbol rejected");
    // R4 unmatched symbol abandons the message, decoder recovers afterwards
    no_msg(10, 64'h2AB, 64, 3, "R4 unmatched symbol abandons");
    good_msg(10, 64'h2AB, "R4 recovery");
    // R12 too many symbols
    no_msg(49, 64'h1_5555_AAAA_0F0F, 64, -1, "R12 49 symbols abandoned");
    good_msg(48, 64'h5555_AAAA_0F0F, "R12 48 symbols accepted");
    // R5 length limits
    min_len = 5'd4; max_len = 6'd20;
    no_msg(3, 64'h5, 64, -1, "R5 below min length rejected");
    good_msg(4, 64'h9, "R5 min length");
    good_msg(20, 64'hC3A5F, "R5 max length");
    no_msg(21, 64'h1C3A5F, 64, -1, "R5 above max length rejected");
    min_len = 5'd2; max_len = 6'd48;

    // R9 held message is not overwritten
    send(16, 64'hA5C3, 64, -1);
    wait_end();
    check(got_v, "R9 first message valid", 64'(got_v), 64'd1);
    send(16, 64'h1234, 64, -1);
    repeat (150) @(negedge clk);
    check(valid, "R9 still valid while held", 64'(valid), 64'd1);
    check(data == 48'hA5C3, "R9 data unchanged while held", 64'(data), 64'hA5C3);
    do_ack();
    check(!valid, "R9 ack clears valid", 64'(valid), 64'd0);
    good_msg(16, 64'h1234, "R9 re-armed");

    // R11 disable clears valid and blocks decoding
    send(8, 64'h96, 64, -1);
    wait_end();
    check(got_v, "R11 message before disable", 64'(got_v), 64'd1);
    en = 1'b0;
    @(negedge clk);
    check(!valid, "R11 disable clears valid", 64'(valid), 64'd0);
    no_msg(8, 64'h96, 64, -1, "R11 no decode while disabled");
    en = 1'b1;
    @(negedge clk);

    // R3 zero takes priority when both windows match
    o_pmin = z_pmin; o_pmax = z_pmax; o_wmin = z_wmin; o_wmax = z_wmax;
    good_msg(8, 64'h0, "R3 zero priority");
    o_pmin = 8'd15; o_pmax = 8'd17; o_wmin = 8'd6; o_wmax = 8'd10;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule